// File: doc/BRIEF.md
# Packet Filter Load/Store Unit

This block carries out the data-movement part of an accumulator-style packet filter machine. It keeps the accumulator A and the index register X. It also holds a small scratch memory of 32-bit words. Each cycle it may accept one 64-bit instruction. The low byte of that instruction is the opcode and the upper 32 bits are the immediate. The block works out an effective address and reads the packet buffer through a combinational read port. It then selects the bytes the access size asks for, zero-extends them, and writes the result to A or X on the next rising clock edge. Store instructions write a full word from A or X into scratch memory.

The packet read port returns the four bytes that start at the given byte address, with the lowest address in bits 7:0. A packet read that would run past the current packet length is refused. In that case the block raises a one-cycle fault and leaves both registers as they were. Fetch, arithmetic and branching belong to neighbouring blocks.

Top module: `pf_ldst_unit`

## Requirements
- R1: After reset, A, X and the fault output are zero, and every scratch word reads as zero.
- R2: Opcode bits 2:0 give the class. Class 0 writes A, class 1 writes X, class 2 stores A to scratch and class 3 stores X to scratch. Classes 4 to 7 change neither A, X nor scratch memory.
- R3: Opcode bits 4:3 give the size: 0 is a 32-bit word, 1 is the low 16 bits and 2 is the low 8 bits, and narrow results are zero-extended. Size 3 has no effect.
- R4: Opcode bits 7:5 give the mode. In mode 0 the destination takes the immediate (instruction bits 63:32), cut to the access size. Modes 4, 6 and 7 have no effect.
- R5: Mode 1 reads the packet at the immediate byte address, little-endian.
- R6: Mode 2 reads the packet at the immediate plus X. The sum is formed without wrapping, so a sum of 2^32 or more always faults.
- R7: Mode 3 reads the scratch word indexed by the low 4 bits of the immediate; the immediate's upper bits are ignored. The word is cut to the access size.
- R8: Mode 5 reads the packet at the immediate address, cut to the access size. It writes the low 4 bits of that value multiplied by four, so the result bits 31:6 and 1:0 are zero.
- R9: A packet-mode load (modes 1, 2 and 5) faults when its address plus its size in bytes exceeds the packet length, capped at 4096. The fault output is high for exactly the cycle after the instruction, and A and X are unchanged.
- R10: Results appear one clock edge after an instruction is accepted with insn_valid high; with insn_valid low, nothing changes.
- R11: Stores write the full 32-bit register to the word indexed by the low 4 bits of the immediate, whatever the size and mode fields hold, and leave A and X unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_valid | input | 1 | Instruction present this cycle |
| insn | input | 64 | Instruction: opcode in 7:0, immediate in 63:32 |
| pkt_len | input | 13 | Current packet length in bytes |
| pkt_addr | output | 12 | Packet read byte address |
| pkt_rdata | input | 32 | Four packet bytes from pkt_addr upward, lowest address in bits 7:0 |
| acc_o | output | 32 | Accumulator A |
| idx_o | output | 32 | Index register X |
| fault_o | output | 1 | Bounds fault for the previous instruction |

## Verification
Every result of this block, whether A, X, a scratch word or the fault flag, lands on the single rising edge that follows the cycle in which insn_valid was high. The bench presents each instruction on a falling edge and removes it on the next falling edge. It compares A, X and the fault flag at that same falling edge, after exactly one rising edge and before the next instruction goes out. Stored scratch words are checked later through mode 3 loads, again one edge after each load.

// File: rtl/pf_ldst_pkg.sv
package pf_ldst_pkg;

   localparam int WORD_W = 32;

   typedef enum logic [2:0] {
      CLS_LDA = 3'd0,
      CLS_LDX = 3'd1,
      CLS_STA = 3'd2,
      CLS_STX = 3'd3,
      CLS_N4  = 3'd4,
      CLS_N5  = 3'd5,
      CLS_N6  = 3'd6,
      CLS_N7  = 3'd7
   } op_class_e;

   typedef enum logic [1:0] {
      SZ_WORD = 2'd0,
      SZ_HALF = 2'd1,
      SZ_BYTE = 2'd2,
      SZ_RSVD = 2'd3
   } op_size_e;

   typedef enum logic [2:0] {
      MD_IMM  = 3'd0,
      MD_ABS  = 3'd1,
      MD_IDX  = 3'd2,
      MD_SCR  = 3'd3,
      MD_R4   = 3'd4,
      MD_HLEN = 3'd5,
      MD_R6   = 3'd6,
      MD_R7   = 3'd7
   } op_mode_e;

   typedef struct packed {
      op_mode_e  mode;
      op_size_e  size;
      op_class_e cls;
   } op_fields_t;

   function automatic logic [WORD_W-1:0] size_fit(logic [WORD_W-1:0] v, op_size_e s);
      case (s)
         SZ_HALF: return {16'h0000, v[15:0]};
         SZ_BYTE: return {24'h000000, v[7:0]};
         default: return v;
      endcase
   endfunction

   function automatic logic [2:0] size_bytes(op_size_e s);
      case (s)
         SZ_WORD: return 3'd4;
         SZ_HALF: return 3'd2;
         SZ_BYTE: return 3'd1;
         default: return 3'd0;
      endcase
   endfunction

   function automatic logic mode_reads_packet(op_mode_e m);
      return (m == MD_ABS) || (m == MD_IDX) || (m == MD_HLEN);
   endfunction

   function automatic logic mode_defined(op_mode_e m);
      return (m == MD_IMM) || (m == MD_SCR) || mode_reads_packet(m);
   endfunction

endpackage

// File: rtl/pf_addr_gen.sv
module pf_addr_gen
   import pf_ldst_pkg::*;
#(
   parameter int PKT_BYTES    = 4096,
   parameter bit BOUNDS_CHECK = 1'b1,
   localparam int PA_W  = $clog2(PKT_BYTES),
   localparam int LEN_W = PA_W + 1
) (
   input  op_mode_e          mode,
   input  op_size_e          size,
   input  logic [WORD_W-1:0] imm,
   input  logic [WORD_W-1:0] idx,
   input  logic [LEN_W-1:0]  pkt_len,
   output logic [PA_W-1:0]   pkt_addr,
   output logic              pkt_rd,
   output logic              beyond
);

   localparam int EA_W  = WORD_W + 1;
   localparam int END_W = WORD_W + 2;

   logic [EA_W-1:0] ea;

   always_comb begin
      if (mode == MD_IDX) ea = {1'b0, imm} + {1'b0, idx};
      else                ea = {1'b0, imm};
   end

   assign pkt_addr = ea[PA_W-1:0];
   assign pkt_rd   = mode_reads_packet(mode) && (size != SZ_RSVD);

   generate
      if (BOUNDS_CHECK) begin : g_bounds
         logic [END_W-1:0] end_a;
         logic [END_W-1:0] limit;
         always_comb begin
            end_a = {1'b0, ea} + END_W'(size_bytes(size));
            if (pkt_len > LEN_W'(PKT_BYTES)) limit = END_W'(PKT_BYTES);
            else                            limit = END_W'(pkt_len);
            beyond = pkt_rd && (end_a > limit);
         end
      end else begin : g_nobounds
         logic unused_bounds;
         assign unused_bounds = ^{ea[EA_W-1:PA_W], pkt_len};
         assign beyond = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pf_lane_sel.sv
module pf_lane_sel
   import pf_ldst_pkg::*;
(
   input  op_mode_e          mode,
   input  op_size_e          size,
   input  logic [WORD_W-1:0] imm,
   input  logic [WORD_W-1:0] pkt_data,
   input  logic [WORD_W-1:0] scr_data,
   output logic [WORD_W-1:0] value,
   output logic              legal
);

   logic [WORD_W-1:0] raw;
   logic [WORD_W-1:0] fitted;

   always_comb begin
      case (mode)
         MD_IMM:  raw = imm;
         MD_SCR:  raw = scr_data;
         default: raw = pkt_data;
      endcase
      fitted = size_fit(raw, size);
      if (mode == MD_HLEN) value = {{(WORD_W-6){1'b0}}, fitted[3:0], 2'b00};
      else                 value = fitted;
      legal = mode_defined(mode) && (size != SZ_RSVD);
   end

endmodule

// File: rtl/pf_scratch.sv
module pf_scratch
   import pf_ldst_pkg::*;
#(
   parameter int SCR_WORDS = 16,
   localparam int SA_W = $clog2(SCR_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SA_W-1:0]   wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [SA_W-1:0]   rd_idx,
   output logic [WORD_W-1:0] rd_data
);

   logic [SCR_WORDS-1:0] we_vec;
   logic [WORD_W-1:0]    words [SCR_WORDS];

   generate
      for (genvar w = 0; w < SCR_WORDS; w++) begin : g_word
         logic [WORD_W-1:0] word_q;
         assign we_vec[w] = wr_en && (wr_idx == SA_W'(w));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         word_q <= '0;
            else if (we_vec[w]) word_q <= wr_data;
         end
         assign words[w] = word_q;
      end
   endgenerate

   assign rd_data = words[rd_idx];

   // R11: a store touches exactly one word
   p_one_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($countones(we_vec) == 1));
   p_no_stray_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> (we_vec == '0));

endmodule

// File: rtl/pf_ldst_unit.sv
module pf_ldst_unit
   import pf_ldst_pkg::*;
#(
   parameter int PKT_BYTES    = 4096,
   parameter int SCR_WORDS    = 16,
   parameter bit BOUNDS_CHECK = 1'b1,
   localparam int PA_W  = $clog2(PKT_BYTES),
   localparam int LEN_W = PA_W + 1,
   localparam int SA_W  = $clog2(SCR_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_valid,
   input  logic [63:0]       insn,
   input  logic [LEN_W-1:0]  pkt_len,
   output logic [PA_W-1:0]   pkt_addr,
   input  logic [WORD_W-1:0] pkt_rdata,
   output logic [WORD_W-1:0] acc_o,
   output logic [WORD_W-1:0] idx_o,
   output logic              fault_o
);

   generate
      if ((1 << PA_W) != PKT_BYTES) begin : g_chk_pkt
         $error("PKT_BYTES must be a power of two");
      end
      if ((1 << SA_W) != SCR_WORDS || SCR_WORDS < 2) begin : g_chk_scr
         $error("SCR_WORDS must be a power of two, at least 2");
      end
   endgenerate

   op_fields_t        op;
   logic [WORD_W-1:0] imm;
   logic [WORD_W-1:0] acc_q, idx_q;
   logic              fault_q;
   logic              pkt_rd, beyond;
   logic [WORD_W-1:0] scr_rd, ld_val, st_data;
   logic              ld_legal, is_load, take, flt, st_en;
   logic              unused_insn;

   assign op          = op_fields_t'(insn[7:0]);
   assign imm         = insn[63:32];
   assign unused_insn = ^{insn[31:8], pkt_rd};

   pf_addr_gen #(
      .PKT_BYTES    (PKT_BYTES),
      .BOUNDS_CHECK (BOUNDS_CHECK)
   ) u_agen (
      .mode     (op.mode),
      .size     (op.size),
      .imm      (imm),
      .idx      (idx_q),
      .pkt_len  (pkt_len),
      .pkt_addr (pkt_addr),
      .pkt_rd   (pkt_rd),
      .beyond   (beyond)
   );

   pf_lane_sel u_lane (
      .mode     (op.mode),
      .size     (op.size),
      .imm      (imm),
      .pkt_data (pkt_rdata),
      .scr_data (scr_rd),
      .value    (ld_val),
      .legal    (ld_legal)
   );

   assign st_en   = insn_valid && ((op.cls == CLS_STA) || (op.cls == CLS_STX));
   assign st_data = (op.cls == CLS_STX) ? idx_q : acc_q;

   pf_scratch #(
      .SCR_WORDS (SCR_WORDS)
   ) u_scr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (st_en),
      .wr_idx  (imm[SA_W-1:0]),
      .wr_data (st_data),
      .rd_idx  (imm[SA_W-1:0]),
      .rd_data (scr_rd)
   );

   assign is_load = (op.cls == CLS_LDA) || (op.cls == CLS_LDX);
   assign take    = insn_valid && is_load && ld_legal;
   assign flt     = take && beyond;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         idx_q   <= '0;
         fault_q <= 1'b0;
      end else begin
         fault_q <= flt;
         if (take && !beyond) begin
            if (op.cls == CLS_LDX) idx_q <= ld_val;
            else                   acc_q <= ld_val;
         end
      end
   end

   assign acc_o   = acc_q;
   assign idx_o   = idx_q;
   assign fault_o = fault_q;

   // signals observed one edge later by the checks below
   logic hlen_ld, byte_ld;
   assign hlen_ld = insn_valid && is_load && (op.mode == MD_HLEN) && (op.size != SZ_RSVD);
   assign byte_ld = insn_valid && (op.cls == CLS_LDA) && (op.size == SZ_BYTE) && mode_defined(op.mode);

   p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (acc_o == $past(acc_o)) && (idx_o == $past(idx_o)));
   p_fault_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> $past(insn_valid));
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_valid |=> $stable(acc_o) && $stable(idx_o) && !fault_o);
   p_hlen_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hlen_ld && (op.cls == CLS_LDA) |=> fault_o || ((acc_o[1:0] == 2'b00) && (acc_o[WORD_W-1:6] == '0)));
   p_byte_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ld |=> fault_o || (acc_o[WORD_W-1:8] == '0));
   p_store_keeps_regs_r11: assert property (@(posedge clk) disable iff (!rst_n)
      st_en |=> $stable(acc_o) && $stable(idx_o) && !fault_o);

endmodule

// File: tb/pf_ldst_unit_test.sv
`timescale 1ns/1ps
module pf_ldst_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_valid = 1'b0;
   logic [63:0] insn = '0;
   logic [12:0] pkt_len = '0;
   logic [11:0] pkt_addr;
   logic [31:0] pkt_rdata;
   logic [31:0] acc_o, idx_o;
   logic        fault_o;

   int checks = 0;
   int fails  = 0;
   logic [31:0] m_a = '0, m_x = '0;
   logic [31:0] m_scr [16];

   always #10 clk = ~clk;

   pf_ldst_unit uut (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
      .pkt_len(pkt_len), .pkt_addr(pkt_addr), .pkt_rdata(pkt_rdata),
      .acc_o(acc_o), .idx_o(idx_o), .fault_o(fault_o)
   );

   function automatic logic [7:0] pb(longint i);
      return 8'((i * 37 + 11) & 255);
   endfunction

   function automatic logic [31:0] pword(longint a);
      return {pb(a + 3), pb(a + 2), pb(a + 1), pb(a)};
   endfunction

   always_comb pkt_rdata = pword(longint'(pkt_addr));

   function automatic logic [7:0] opc(int md, int sz, int cl);
      return {3'(md), 2'(sz), 3'(cl)};
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   task automatic run(logic [7:0] op, logic [31:0] imm, string tag);
      int cl = int'(op[2:0]);
      int sz = int'(op[4:3]);
      int md = int'(op[7:5]);
      longint nb = (sz == 0) ? 4 : (sz == 1) ? 2 : 1;
      longint lim = (pkt_len > 4096) ? 4096 : longint'(pkt_len);
      longint ea;
      logic [31:0] mask = (sz == 0) ? 32'hFFFFFFFF : (sz == 1) ? 32'h0000FFFF : 32'h000000FF;
      logic [31:0] val = '0;
      logic        e_f = 1'b0;
      logic        wr = 1'b0;
      string       t = tag;
      ea = longint'(imm) + ((md == 2) ? longint'(m_x) : 0);
      if (cl <= 1 && sz != 3 && (md <= 3 || md == 5)) begin
         wr = 1'b1;
         if (md == 1 || md == 2 || md == 5) begin
            if (ea + nb > lim) begin
               e_f = 1'b1;
               wr  = 1'b0;
               t   = "R9";
            end else begin
               val = pword(ea) & mask;
               if (md == 5) val = {26'h0, val[3:0], 2'b00};
            end
         end else if (md == 0) begin
            val = imm & mask;
         end else begin
            val = m_scr[imm[3:0]] & mask;
         end
      end
      @(negedge clk);
      insn_valid = 1'b1;
      insn = {imm, 24'h0, op};
      @(negedge clk);
      insn_valid = 1'b0;
      if (wr) begin
         if (cl == 0) m_a = val;
         else         m_x = val;
      end
      if (cl == 2) m_scr[imm[3:0]] = m_a;
      if (cl == 3) m_scr[imm[3:0]] = m_x;
      chk(t, "acc", acc_o, m_a);
      chk(t, "idx", idx_o, m_x);
      chk(t, "fault", {31'h0, fault_o}, {31'h0, e_f});
   endtask

   initial begin
      #3_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) m_scr[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "acc", acc_o, 32'h0);
      chk("R1", "idx", idx_o, 32'h0);
      chk("R1", "fault", {31'h0, fault_o}, 32'h0);
      run(opc(3, 0, 0), 32'h7, "R1");
      run(opc(3, 0, 1), 32'hF, "R1");

      // R4, R3: immediate loads at every size, both destinations
      for (int cl = 0; cl < 2; cl++)
         for (int sz = 0; sz < 4; sz++) begin
            run(opc(0, sz, cl), 32'hDEADBEEF, (sz == 3) ? "R3" : "R4");
            run(opc(0, sz, cl), 32'h800180FF, (sz == 3) ? "R3" : "R4");
            run(opc(0, sz, cl), 32'h12345678, (sz == 3) ? "R3" : "R4");
         end

      // R5: absolute packet reads around the end of a 64-byte packet
      pkt_len = 13'd64;
      for (int cl = 0; cl < 2; cl++)
         for (int sz = 0; sz < 3; sz++)
            for (int a = 0; a < 67; a++) run(opc(1, sz, cl), 32'(a), "R5");

      // R6: indexed reads, including a sum that passes 2^32
      for (int k = 0; k < 4; k++) begin
         logic [31:0] xv = (k == 0) ? 32'd0 : (k == 1) ? 32'd5 : (k == 2) ? 32'd30 : 32'hFFFFFFF0;
         run(opc(0, 0, 1), xv, "R6");
         for (int sz = 0; sz < 3; sz++)
            for (int a = 0; a < 41; a += 3) run(opc(2, sz, 0), 32'(a), "R6");
      end

      // R8: header-length mode
      for (int cl = 0; cl < 2; cl++)
         for (int sz = 0; sz < 3; sz++)
            for (int a = 0; a < 64; a++) run(opc(5, sz, cl), 32'(a), "R8");

      // R9: bounds at small lengths and at the full buffer
      for (int len = 0; len < 5; len++) begin
         pkt_len = 13'(len);
         for (int sz = 0; sz < 3; sz++)
            for (int a = 0; a < 5; a++) run(opc(1, sz, 0), 32'(a), "R9");
      end
      pkt_len = 13'd4096;
      for (int sz = 0; sz < 3; sz++)
         for (int a = 4090; a < 4097; a++) run(opc(1, sz, 1), 32'(a), "R9");

      // R11, R7: stores into every word, immediate upper bits set
      for (int i = 0; i < 16; i++) begin
         run(opc(0, 0, 0), 32'hA5C30000 ^ (32'(i) * 32'h01010101), "R11");
         run(opc(3, 2, 2), 32'(i) | 32'h00000730, "R11");
         if (i % 3 == 0) begin
            run(opc(0, 0, 1), 32'h5A000000 + 32'(i * 77), "R11");
            run(opc(7, 1, 3), 32'(i) | 32'hFFFF0000, "R11");
         end
      end
      for (int i = 0; i < 16; i++)
         for (int sz = 0; sz < 3; sz++) begin
            run(opc(3, sz, 0), 32'(i) | 32'h00012340, "R7");
            run(opc(3, sz, 1), 32'(i), "R7");
         end

      // R2: classes 4..7 do nothing; R4: undefined modes do nothing
      run(opc(0, 0, 0), 32'h11223344, "R2");
      run(opc(0, 0, 1), 32'h55667788, "R2");
      pkt_len = 13'd64;
      for (int cl = 4; cl < 8; cl++)
         for (int md = 0; md < 8; md++) run(opc(md, 0, cl), 32'h3, "R2");
      for (int cl = 0; cl < 2; cl++) begin
         run(opc(4, 0, cl), 32'h4, "R4");
         run(opc(6, 1, cl), 32'h4, "R4");
         run(opc(7, 2, cl), 32'h4, "R4");
         for (int md = 0; md < 6; md++) run(opc(md, 3, cl), 32'h2, "R3");
      end
      for (int i = 0; i < 16; i++) run(opc(3, 0, 0), 32'(i), "R2");

      // R10: an instruction with valid low changes nothing
      @(negedge clk);
      insn = {32'hCAFEF00D, 24'h0, opc(0, 0, 0)};
      insn_valid = 1'b0;
      @(negedge clk);
      chk("R10", "acc", acc_o, m_a);
      chk("R10", "fault", {31'h0, fault_o}, 32'h0);
      insn = {32'd100, 24'h0, opc(1, 0, 1)};
      @(negedge clk);
      chk("R10", "idx", idx_o, m_x);
      chk("R10", "fault", {31'h0, fault_o}, 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule